// File: doc/BRIEF.md
# Interrupt-Driven Single-Transfer Data Mover

This block moves one byte or one 16-bit word across a synchronous bus each time a peripheral raises a request. A 5-bit control field, loaded through an 8-bit configuration port, sets four things. The first is the direction of the move: from the I/O address into the buffer, or from the buffer to the I/O address. The second is the data width. The third and fourth are whether the I/O pointer advances and whether the buffer pointer advances after each move. The block holds an I/O address pointer, a buffer address pointer and a transfer counter. All three are loaded together with the control field.

A move is one read cycle on the bus followed by one write cycle. The data returned by the read is driven back out as the write data. When the counter reaches zero the block raises a one-cycle done pulse and stops serving. Later requests are then returned to the ordinary interrupt path as a one-cycle hand-back pulse. A request may carry a termination flag. When termination is enabled in the control field, such a request ends the service without any bus activity and sets a sticky terminated status. That status is separate from the done pulse.

Top module: `irq_xfer_mover`

## Requirements
- R1: `ctrlOut` returns the value last loaded on `cfgData`, with bits 7:5 always reading 0. The field positions are: bit 4 holds the I/O pointer, bit 3 selects word width, bit 2 holds the buffer pointer, bit 1 sets the direction, and bit 0 enables termination.
- R2: A request sampled at clock edge k starts a move when the service is active. `busRd` is high for the one cycle after edge k+1, and `busWr` is high for the one cycle after edge k+2. The two strobes are never high together.
- R3: When bit 1 is 0, the read address is the I/O pointer zero-extended and the write address is the buffer pointer. When bit 1 is 1, the two addresses are swapped. In every case `busWdata` equals the `busRdata` returned for the read.
- R4: `busWide` equals bit 3 during both strobes. A pointer that advances steps by 2 for a word move and by 1 for a byte move.
- R5: When bit 4 is 0, the I/O pointer increases by the step at the end of each move. When bit 4 is 1, it holds its value.
- R6: When bit 2 is 0, the low 16 bits of the buffer pointer increase by the step at the end of each move and wrap without carrying into the upper bits. When bit 2 is 1, the buffer pointer holds its value.
- R7: `cntOut` decrements by one at the end of each move. The move that brings it to zero raises `done` for exactly the one cycle that follows the write cycle.
- R8: While the service is inactive, each request produces a one-cycle `handback` pulse one cycle after its decision edge and no bus strobe. The service is inactive after completion, after termination, or after loading a count of zero.
- R9: When bit 0 is 1, a request with `reqTerm` high sets `terminated`, makes no bus access, does not raise `done`, and makes the service inactive.
- R10: When bit 0 is 0, a request with `reqTerm` high is served as an ordinary move and leaves `terminated` at 0.
- R11: `busy` is high exactly during the read and write cycles. A request that arrives while busy is held and is served once the current move ends.
- R12: A configuration load clears `terminated` and makes the service active whenever the loaded count is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgLoad | input | 1 | Loads the control field, both pointers and the count |
| cfgData | input | 8 | Control value; bits 7:5 are discarded |
| ioPtrIn | input | IO_W | I/O pointer load value |
| bufPtrIn | input | BUF_W | Buffer pointer load value |
| cntIn | input | CNT_W | Transfer count load value |
| reqValid | input | 1 | Peripheral request, one cycle |
| reqTerm | input | 1 | Marks the request as a termination request |
| busAddr | output | BUF_W | Bus address during a strobe |
| busRd | output | 1 | Read strobe |
| busWr | output | 1 | Write strobe |
| busWide | output | 1 | Word access when high, byte access when low |
| busWdata | output | 16 | Write data |
| busRdata | input | 16 | Read data, valid the cycle after `busRd` |
| busy | output | 1 | A move is in progress |
| done | output | 1 | Count-exhausted pulse |
| handback | output | 1 | Request returned to the normal interrupt path |
| terminated | output | 1 | Sticky early-termination status |
| ctrlOut | output | 8 | Control field readback |
| ioPtrOut | output | IO_W | Current I/O pointer |
| bufPtrOut | output | BUF_W | Current buffer pointer |
| cntOut | output | CNT_W | Remaining count |

## Verification
The bench drives the block with several patterns.
- A word-wide run into the buffer starts the buffer pointer just below a 64K boundary. This separates a low-16 wrap from a full-width carry.
- A byte-wide run toward the I/O side holds both pointers fixed. This separates the hold bits from the width bit and shows the address swap.
- Requests flagged for termination are issued with termination enabled and with it disabled. This separates the abort path from an ordinary move.
- A second request is issued while the first is still moving. This shows that it is held rather than lost.
- Requests are issued after the count is exhausted and after a zero-count load. These show that the request is handed back instead of reaching the bus.

// File: rtl/irq_xfer_pkg.sv
package irq_xfer_pkg;
  // control field bit positions
  localparam int CTL_IOFIX  = 4;
  localparam int CTL_WIDE   = 3;
  localparam int CTL_BUFFIX = 2;
  localparam int CTL_DIR    = 1;
  localparam int CTL_TERMEN = 0;
  localparam int CTL_W      = 5;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} xferState_t;

  // control -> datapath
  typedef struct packed {
    logic rdPhase;
    logic wrPhase;
    logic commit;
    logic terminate;
  } xferStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic svcOn;
    logic termEn;
    logic cntIsOne;
  } dpStatus_t;
endpackage

// File: rtl/irq_xfer_ctrl.sv
module irq_xfer_ctrl
  import irq_xfer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqTerm,
  input  dpStatus_t   stat,
  output xferStrobe_t stb,
  output logic        busy,
  output logic        done,
  output logic        handback
);
  xferState_t state;
  logic pend, pendTerm;
  logic decide, abortReq, startXfer;

  assign decide    = (state == ST_IDLE) && pend;
  assign abortReq  = pendTerm && stat.termEn;
  assign startXfer = decide && stat.svcOn && !abortReq;

  assign stb.rdPhase   = (state == ST_READ);
  assign stb.wrPhase   = (state == ST_WRITE);
  assign stb.commit    = (state == ST_WRITE);
  assign stb.terminate = decide && stat.svcOn && abortReq;
  assign busy          = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pend     <= 1'b0;
      pendTerm <= 1'b0;
      done     <= 1'b0;
      handback <= 1'b0;
    end else begin
      done     <= stb.commit && stat.cntIsOne;
      handback <= decide && !stat.svcOn;
      unique case (state)
        ST_IDLE:  if (startXfer) state <= ST_READ;
        ST_READ:  state <= ST_WRITE;
        ST_WRITE: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
      // a new request wins over the clear of the one just decided
      if (reqValid) begin
        pend     <= 1'b1;
        pendTerm <= reqTerm;
      end else if (decide) begin
        pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_xfer_dpath.sv
module irq_xfer_dpath
  import irq_xfer_pkg::*;
#(
  parameter int IO_W  = 16,
  parameter int BUF_W = 24,
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic [7:0]        cfgData,
  input  logic [IO_W-1:0]   ioPtrIn,
  input  logic [BUF_W-1:0]  bufPtrIn,
  input  logic [CNT_W-1:0]  cntIn,
  input  xferStrobe_t       stb,
  input  logic [15:0]       busRdata,
  output dpStatus_t         stat,
  output logic [BUF_W-1:0]  busAddr,
  output logic              busWide,
  output logic [15:0]       busWdata,
  output logic [7:0]        ctrlOut,
  output logic [IO_W-1:0]   ioPtrOut,
  output logic [BUF_W-1:0]  bufPtrOut,
  output logic [CNT_W-1:0]  cntOut,
  output logic              terminated
);
  localparam int LOW_W = 16;
  localparam int HI_W  = BUF_W - LOW_W;

  logic [CTL_W-1:0] ctl;
  logic [IO_W-1:0]  ioPtr;
  logic [BUF_W-1:0] bufPtr;
  logic [CNT_W-1:0] cnt;
  logic             svcOn;
  logic [LOW_W-1:0] step;
  logic [BUF_W-1:0] ioAddr;
  logic [LOW_W-1:0] bufLowNext;

  assign step       = ctl[CTL_WIDE] ? LOW_W'(2) : LOW_W'(1);
  assign ioAddr     = BUF_W'(ioPtr);
  assign bufLowNext = bufPtr[LOW_W-1:0] + step;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctl        <= '0;
      ioPtr      <= '0;
      bufPtr     <= '0;
      cnt        <= '0;
      svcOn      <= 1'b0;
      terminated <= 1'b0;
    end else if (cfgLoad) begin
      ctl        <= cfgData[CTL_W-1:0];
      ioPtr      <= ioPtrIn;
      bufPtr     <= bufPtrIn;
      cnt        <= cntIn;
      svcOn      <= (cntIn != '0);
      terminated <= 1'b0;
    end else begin
      if (stb.commit) begin
        if (!ctl[CTL_IOFIX])  ioPtr <= ioPtr + IO_W'(step);
        if (!ctl[CTL_BUFFIX]) bufPtr <= {bufPtr[BUF_W-1:LOW_W], bufLowNext};
        cnt <= cnt - CNT_W'(1);
        if (cnt == CNT_W'(1)) svcOn <= 1'b0;
      end
      if (stb.terminate) begin
        terminated <= 1'b1;
        svcOn      <= 1'b0;
      end
    end
  end

  always_comb begin
    busAddr = '0;
    if (stb.rdPhase)      busAddr = ctl[CTL_DIR] ? bufPtr : ioAddr;
    else if (stb.wrPhase) busAddr = ctl[CTL_DIR] ? ioAddr : bufPtr;
  end

  assign busWide  = (stb.rdPhase || stb.wrPhase) && ctl[CTL_WIDE];
  assign busWdata = stb.wrPhase ? busRdata : '0;

  assign ctrlOut   = {{(8-CTL_W){1'b0}}, ctl};
  assign ioPtrOut  = ioPtr;
  assign bufPtrOut = bufPtr;
  assign cntOut    = cnt;

  assign stat.svcOn    = svcOn;
  assign stat.termEn   = ctl[CTL_TERMEN];
  assign stat.cntIsOne = (cnt == CNT_W'(1));

  if (HI_W < 1) begin : g_bad_width
    initial $error("BUF_W must exceed 16");
  end
endmodule

// File: rtl/irq_xfer_mover.sv
module irq_xfer_mover
  import irq_xfer_pkg::*;
#(
  parameter int IO_W  = 16,
  parameter int BUF_W = 24,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgLoad,
  input  logic [7:0]       cfgData,
  input  logic [IO_W-1:0]  ioPtrIn,
  input  logic [BUF_W-1:0] bufPtrIn,
  input  logic [CNT_W-1:0] cntIn,
  input  logic             reqValid,
  input  logic             reqTerm,
  output logic [BUF_W-1:0] busAddr,
  output logic             busRd,
  output logic             busWr,
  output logic             busWide,
  output logic [15:0]      busWdata,
  input  logic [15:0]      busRdata,
  output logic             busy,
  output logic             done,
  output logic             handback,
  output logic             terminated,
  output logic [7:0]       ctrlOut,
  output logic [IO_W-1:0]  ioPtrOut,
  output logic [BUF_W-1:0] bufPtrOut,
  output logic [CNT_W-1:0] cntOut
);
  xferStrobe_t stb;
  dpStatus_t   stat;

  irq_xfer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqTerm(reqTerm),
    .stat(stat), .stb(stb), .busy(busy), .done(done), .handback(handback)
  );

  irq_xfer_dpath #(.IO_W(IO_W), .BUF_W(BUF_W), .CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgData(cfgData),
    .ioPtrIn(ioPtrIn), .bufPtrIn(bufPtrIn), .cntIn(cntIn), .stb(stb),
    .busRdata(busRdata), .stat(stat), .busAddr(busAddr), .busWide(busWide),
    .busWdata(busWdata), .ctrlOut(ctrlOut), .ioPtrOut(ioPtrOut),
    .bufPtrOut(bufPtrOut), .cntOut(cntOut), .terminated(terminated)
  );

  assign busRd = stb.rdPhase;
  assign busWr = stb.wrPhase;
endmodule

// File: rtl/irq_xfer_chk.sv
module irq_xfer_chk #(
  parameter int IO_W  = 16,
  parameter int BUF_W = 24,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgLoad,
  input logic             busRd,
  input logic             busWr,
  input logic             busy,
  input logic             done,
  input logic             handback,
  input logic             terminated,
  input logic [7:0]       ctrlOut,
  input logic [IO_W-1:0]  ioPtrOut,
  input logic [BUF_W-1:0] bufPtrOut,
  input logic [CNT_W-1:0] cntOut
);
  a_r2_write_follows_read: assert property (@(posedge clk) disable iff (!rstN)
    busRd |=> busWr);
  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busWr));
  a_r11_busy_covers_strobes: assert property (@(posedge clk) disable iff (!rstN)
    (busRd || busWr) |-> busy);
  a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r7_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !cfgLoad) |=> (cntOut == $past(cntOut) - CNT_W'(1)));
  a_r5_io_held: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && ctrlOut[4] && !cfgLoad) |=> $stable(ioPtrOut));
  a_r6_upper_kept: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !cfgLoad) |=> (bufPtrOut[BUF_W-1:16] == $past(bufPtrOut[BUF_W-1:16])));
  a_r8_handback_quiet: assert property (@(posedge clk) disable iff (!rstN)
    handback |-> (!busRd && !busWr));
  a_r9_abort_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $rose(terminated) |-> (!busRd && !busWr && !done));
endmodule

bind irq_xfer_mover irq_xfer_chk #(.IO_W(IO_W), .BUF_W(BUF_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .busRd(busRd), .busWr(busWr),
  .busy(busy), .done(done), .handback(handback), .terminated(terminated),
  .ctrlOut(ctrlOut), .ioPtrOut(ioPtrOut), .bufPtrOut(bufPtrOut), .cntOut(cntOut)
);

// File: tb/irq_xfer_mover_tb.sv
module irq_xfer_mover_tb;
  localparam int IO_W = 16, BUF_W = 24, CNT_W = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgLoad = 1'b0, reqValid = 1'b0, reqTerm = 1'b0;
  logic [7:0] cfgData = '0;
  logic [IO_W-1:0] ioPtrIn = '0;
  logic [BUF_W-1:0] bufPtrIn = '0;
  logic [CNT_W-1:0] cntIn = '0;
  logic [BUF_W-1:0] busAddr, bufPtrOut;
  logic busRd, busWr, busWide, busy, done, handback, terminated;
  logic [15:0] busWdata, busRdata;
  logic [7:0] ctrlOut;
  logic [IO_W-1:0] ioPtrOut;
  logic [CNT_W-1:0] cntOut;

  int checks = 0, failures = 0, cycles = 0;
  bit cmpOn = 1'b0, finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  irq_xfer_mover #(.IO_W(IO_W), .BUF_W(BUF_W), .CNT_W(CNT_W)) u_dut (.*);

  // bench memory: registered read data derived from the address
  always @(posedge clk) if (busRd) busRdata <= busAddr[15:0] ^ 16'h5A3C;
  initial busRdata = '0;

  // behavioural reference, advanced on every rising edge
  int mState = 0, mCtrl = 0, mIo = 0, mBuf = 0, mCnt = 0, mRdAddr = 0;
  bit mPend = 0, mPendTerm = 0, mSvc = 0, mTerm = 0, mDone = 0, mHand = 0;

  always @(posedge clk) begin
    int stepV;
    if (!rstN) begin
      mState = 0; mCtrl = 0; mIo = 0; mBuf = 0; mCnt = 0;
      mPend = 0; mPendTerm = 0; mSvc = 0; mTerm = 0; mDone = 0; mHand = 0;
    end else begin
      bit decided;
      decided = 0; mDone = 0; mHand = 0;
      stepV = mCtrl[3] ? 2 : 1;
      case (mState)
        0: if (mPend) begin
             decided = 1;
             if (!mSvc) mHand = 1;
             else if (mPendTerm && mCtrl[0]) begin mTerm = 1; mSvc = 0; end
             else begin
               mState = 1;
               mRdAddr = mCtrl[1] ? mBuf : mIo;
             end
           end
        1: mState = 2;
        default: begin
          mState = 0;
          if (!mCtrl[4]) mIo = (mIo + stepV) & 16'hFFFF;
          if (!mCtrl[2]) mBuf = (mBuf & 32'hFF0000) | ((mBuf + stepV) & 32'hFFFF);
          mCnt = mCnt - 1;
          if (mCnt == 0) begin mDone = 1; mSvc = 0; end
        end
      endcase
      if (reqValid) begin mPend = 1; mPendTerm = reqTerm; end
      else if (decided) mPend = 0;
      if (cfgLoad) begin
        mCtrl = cfgData & 8'h1F; mIo = ioPtrIn; mBuf = bufPtrIn; mCnt = cntIn;
        mTerm = 0; mSvc = (cntIn != 0);
      end
    end
    cmpOn = 1'b1;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) if (cmpOn) begin
    check("R2 read strobe", int'(busRd), int'(mState == 1));
    check("R2 write strobe", int'(busWr), int'(mState == 2));
    check("R11 busy", int'(busy), int'(mState != 0));
    check("R7 done", int'(done), int'(mDone));
    check("R8 handback", int'(handback), int'(mHand));
    check("R9 terminated", int'(terminated), int'(mTerm));
    check("R1 control readback", int'(ctrlOut), mCtrl);
    check("R5 io pointer", int'(ioPtrOut), mIo);
    check("R6 buffer pointer", int'(bufPtrOut), mBuf);
    check("R7 count", int'(cntOut), mCnt);
    if (mState == 1) begin
      check("R3 read address", int'(busAddr), mCtrl[1] ? mBuf : mIo);
      check("R4 width on read", int'(busWide), int'(mCtrl[3]));
    end
    if (mState == 2) begin
      check("R3 write address", int'(busAddr), mCtrl[1] ? mIo : mBuf);
      check("R4 width on write", int'(busWide), int'(mCtrl[3]));
      check("R3 write data", int'(busWdata), (mRdAddr & 16'hFFFF) ^ 16'h5A3C);
    end
  end

  task automatic loadCfg(input logic [7:0] c, input int io, input int bf, input int n);
    cfgData = c; ioPtrIn = IO_W'(io); bufPtrIn = BUF_W'(bf); cntIn = CNT_W'(n);
    cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
  endtask

  task automatic request(input bit term);
    reqValid = 1'b1; reqTerm = term;
    @(negedge clk);
    reqValid = 1'b0; reqTerm = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog expired");
      finish();
    end
  end

  initial begin
    idle(3);
    check("R11 reset busy", int'(busy), 0);
    check("R7 reset done", int'(done), 0);
    rstN = 1'b1;
    idle(1);

    // word moves into buffer, reserved bits set, buffer low half near wrap (R1, R4, R6)
    loadCfg(8'hE8, 'h0100, 'h12FFFE, 3);
    check("R1 reserved bits read zero", int'(ctrlOut), 'h08);
    for (int i = 0; i < 3; i++) begin request(0); idle(5); end
    check("R6 low half wrapped, upper kept", int'(bufPtrOut), 'h120004);
    check("R7 count exhausted", int'(cntOut), 0);
    request(0); idle(4);  // R8: handed back

    // byte moves toward I/O, both pointers held (R3, R5, R6)
    loadCfg(8'h16, 'h0040, 'h003000, 2);
    for (int i = 0; i < 2; i++) begin request(0); idle(5); end
    check("R5 io held", int'(ioPtrOut), 'h0040);

    // termination enabled (R9), then request after abort (R8)
    loadCfg(8'h01, 'h0200, 'h004000, 5);
    request(1); idle(4);
    check("R9 terminated set", int'(terminated), 1);
    check("R9 count untouched", int'(cntOut), 5);
    request(0); idle(4);

    // reload clears terminated (R12); termination disabled moves data (R10)
    loadCfg(8'h00, 'h0300, 'h005000, 2);
    check("R12 terminated cleared", int'(terminated), 0);
    request(1); idle(5);
    check("R10 term flag ignored", int'(terminated), 0);
    check("R10 move counted", int'(cntOut), 1);
    check("R5 byte step", int'(ioPtrOut), 'h0301);

    // second request while busy is held (R11)
    loadCfg(8'h0A, 'h0400, 'h006000, 4);
    request(0); request(0); idle(10);
    check("R11 both moves served", int'(cntOut), 2);

    // zero count load (R8)
    loadCfg(8'h00, 'h0500, 'h007000, 0);
    request(0); idle(4);
    check("R8 zero count untouched", int'(cntOut), 0);

    finish();
  end
endmodule